// File: doc/BRIEF.md
# Delay-Line Phase Programming Sequencer

This block steps a 16-tap receive-clock delay line onto a requested sampling phase. It does so through read-modify-write accesses to the line's 32-bit configuration register. A one-cycle start pulse and a 4-bit phase number begin a fixed sequence of four writes with two status polls between them:

1. Gate the output clock and take manual control.
2. Wait until the output clock reads back as off.
3. Write the tap code.
4. Re-enable the output clock.
5. Wait until it reads back as on.
6. Hand control back to automatic tracking.

The register sits outside the block. Its current value is always visible on a read-data input, and the block issues whole-word writes on a write strobe. Bit 18 of the read data reflects the real state of the output-clock enable.

Each poll is bounded. Attempts are paced by an external microsecond tick, and a poll that runs out of attempts ends the sequence with a timeout pulse. Normal completion gives a done pulse.

Top module: `dll_phase_seq`

## Requirements
- R1: The first write of a sequence clears bit 17 (tracking enable) and bit 18 (output-clock enable), sets bit 19 (manual select) and bit 16 (line enable), and keeps all other bits.
- R2: The tap-code write happens only after bit 18 of the read data has been seen at 0.
- R3: Phase p (0..15) is written as the reflected Gray code p XOR (p>>1) into bits 23:20. For example 5→7, 10→F, 12→A and 15→8.
- R4: Every write keeps the bits it is not defined to change (bits 15:0 and 31:24 always).
- R5: After the tap code, a write sets bit 18, and the block waits until bit 18 of the read data is 1.
- R6: The final write sets bit 17 and clears bit 19. A successful sequence makes exactly four writes.
- R7: In each poll, attempt 1 is the entry cycle and each tick is a further attempt. If the 50th attempt fails, the block pulses timeout, makes no further write and returns to idle.
- R8: A start pulse while busy has no effect on the phase written or on the number of writes.
- R9: Done and timeout are single-cycle pulses and never occur together. Busy is low when either is shown.
- R10: Without ticks a poll waits indefinitely. If the status matches in the same cycle as the final attempt's tick, the sequence continues and no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| phase_i | input | 4 | Requested phase, sampled with start |
| us_tick_i | input | 1 | Microsecond pacing tick |
| cfg_rdata_i | input | 32 | Current configuration register value |
| cfg_wr_o | output | 1 | Register write strobe |
| cfg_wdata_o | output | 32 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed pulse |
| timeout_o | output | 1 | Poll exhausted pulse |

## Verification
The status match and the expiry of a poll's last attempt can land in the same cycle. The bench provokes this by holding the modelled clock-output status stuck, delivering 48 ticks by hand, and then releasing the status on the same clock edge as the 49th tick. The match must win: no timeout pulse appears, and the sequence finishes with done and the expected register value. A separate run keeps the status stuck and checks that timeout appears exactly after that 49th tick and not after the 48th.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int LINE_EN_BIT   = 16;
  localparam int TRACK_EN_BIT  = 17;
  localparam int CLKOUT_EN_BIT = 18;
  localparam int MANUAL_BIT    = 19;
  localparam int TAP_LSB       = 20;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GATE  = 3'd1,
    ST_WOFF  = 3'd2,
    ST_CODE  = 3'd3,
    ST_CKEN  = 3'd4,
    ST_WON   = 3'd5,
    ST_TRACK = 3'd6
  } seq_state_t;
endpackage

// File: rtl/dps_tap_encode.sv
module dps_tap_encode #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] code_o
);
  assign code_o[W-1] = bin_i[W-1];
  for (genvar i = 0; i < W-1; i++) begin : g_refl
    assign code_o[i] = bin_i[i] ^ bin_i[i+1];
  end
endmodule

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
  parameter int TRIES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic met_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TRIES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIES - 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!active_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i && !met_i) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = active_i && !met_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
  import dps_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int PHASE_W    = 4,
  parameter int POLL_TRIES = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               us_tick_i,
  input  logic [REG_W-1:0]   cfg_rdata_i,
  output logic               cfg_wr_o,
  output logic [REG_W-1:0]   cfg_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  seq_state_t         state_q, state_d;
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] tap_code;
  logic               polling, want_on, met, expire;
  logic               done_q, tout_q;
  logic               take_start;

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign polling    = (state_q == ST_WOFF) || (state_q == ST_WON);
  assign want_on    = (state_q == ST_WON);
  assign met        = (cfg_rdata_i[CLKOUT_EN_BIT] == want_on);

  dps_tap_encode #(.W(PHASE_W)) u_enc (
    .bin_i  (phase_q),
    .code_o (tap_code)
  );

  dps_poll_timer #(.TRIES(POLL_TRIES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (polling),
    .met_i    (met),
    .tick_i   (us_tick_i),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_GATE;
      ST_GATE:  state_d = ST_WOFF;
      ST_WOFF:  if (met) state_d = ST_CODE; else if (expire) state_d = ST_IDLE;
      ST_CODE:  state_d = ST_CKEN;
      ST_CKEN:  state_d = ST_WON;
      ST_WON:   if (met) state_d = ST_TRACK; else if (expire) state_d = ST_IDLE;
      ST_TRACK: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cfg_wr_o    = 1'b0;
    cfg_wdata_o = cfg_rdata_i;
    unique case (state_q)
      ST_GATE: begin
        cfg_wr_o                   = 1'b1;
        cfg_wdata_o[TRACK_EN_BIT]  = 1'b0;
        cfg_wdata_o[CLKOUT_EN_BIT] = 1'b0;
        cfg_wdata_o[MANUAL_BIT]    = 1'b1;
        cfg_wdata_o[LINE_EN_BIT]   = 1'b1;
      end
      ST_CODE: begin
        cfg_wr_o                          = 1'b1;
        cfg_wdata_o[TAP_LSB +: PHASE_W]   = tap_code;
      end
      ST_CKEN: begin
        cfg_wr_o                   = 1'b1;
        cfg_wdata_o[CLKOUT_EN_BIT] = 1'b1;
      end
      ST_TRACK: begin
        cfg_wr_o                  = 1'b1;
        cfg_wdata_o[TRACK_EN_BIT] = 1'b1;
        cfg_wdata_o[MANUAL_BIT]   = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TRACK);
      tout_q  <= expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (take_start) phase_q <= phase_i;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tout_q;
endmodule

// File: rtl/dll_phase_seq_chk.sv
module dll_phase_seq_chk
  import dps_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int PHASE_W    = 4,
  parameter int POLL_TRIES = 50
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic               us_tick_i,
  input logic [REG_W-1:0]   cfg_rdata_i,
  input logic               cfg_wr_o,
  input logic [REG_W-1:0]   cfg_wdata_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               timeout_o
);
  AST_GATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o && $rose(busy_o)) |-> (!cfg_wdata_o[TRACK_EN_BIT] && !cfg_wdata_o[CLKOUT_EN_BIT]
      && cfg_wdata_o[MANUAL_BIT] && cfg_wdata_o[LINE_EN_BIT])); // R1

  AST_CODE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o && (cfg_wdata_o[TAP_LSB +: PHASE_W] != cfg_rdata_i[TAP_LSB +: PHASE_W]))
      |-> !cfg_rdata_i[CLKOUT_EN_BIT]); // R2

  AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |-> ((cfg_wdata_o[15:0] == cfg_rdata_i[15:0])
      && (cfg_wdata_o[REG_W-1:24] == cfg_rdata_i[REG_W-1:24]))); // R4

  AST_TRACK_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o && cfg_wdata_o[TRACK_EN_BIT] && !cfg_rdata_i[TRACK_EN_BIT])
      |-> cfg_rdata_i[CLKOUT_EN_BIT]); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_TOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o); // R9

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> (!busy_o && !(done_o && timeout_o))); // R9

  AST_TOUT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !cfg_wr_o); // R7
endmodule

bind dll_phase_seq dll_phase_seq_chk #(
  .REG_W(REG_W), .PHASE_W(PHASE_W), .POLL_TRIES(POLL_TRIES)
) u_chk (.*);

// File: tb/sim_dll_phase_seq.sv
`timescale 1ns/1ps
module sim_dll_phase_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  phase_i = '0;
  logic        us_tick_i;
  logic [31:0] cfg_rdata_i;
  logic        cfg_wr_o, busy_o, done_o, timeout_o;
  logic [31:0] cfg_wdata_o;

  always #2 clk = ~clk;

  dll_phase_seq u0 (.*);

  // register and delay-line model
  logic [31:0] mreg;
  logic [7:0]  ack_sh;
  logic        ld_req = 1'b0;
  logic [31:0] ld_val = '0;
  int          lag = 0;
  logic        hold_en = 1'b0, hold_val = 1'b0;
  int          wr_cnt, done_cnt;
  logic        ack;

  always @(posedge clk) begin
    if (ld_req) begin
      mreg <= ld_val; ack_sh <= {8{ld_val[18]}}; wr_cnt <= 0; done_cnt <= 0;
    end else begin
      if (cfg_wr_o) begin mreg <= cfg_wdata_o; wr_cnt <= wr_cnt + 1; end
      ack_sh <= {ack_sh[6:0], mreg[18]};
      if (done_o) done_cnt <= done_cnt + 1;
    end
  end
  assign ack = hold_en ? hold_val : ((lag == 0) ? mreg[18] : ack_sh[lag-1]);
  assign cfg_rdata_i = {mreg[31:19], ack, mreg[17:0]};

  // tick: automatic every 4 cycles or manual
  logic auto_en = 1'b1, man_t = 1'b0, auto_t = 1'b0;
  logic [1:0] tdiv = '0;
  always @(negedge clk) begin tdiv <= tdiv + 1'b1; auto_t <= (tdiv == 2'd3); end
  assign us_tick_i = auto_en ? auto_t : man_t;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gray(input logic [3:0] p);
    return p ^ (p >> 1);
  endfunction

  function automatic logic [31:0] final_val(input logic [31:0] init, input logic [3:0] p);
    logic [31:0] v;
    v = init;
    v[23:20] = gray(p);
    v[19] = 1'b0; v[18] = 1'b1; v[17] = 1'b1; v[16] = 1'b1;
    return v;
  endfunction

  task automatic load(input logic [31:0] v);
    @(negedge clk); ld_req = 1'b1; ld_val = v;
    @(negedge clk); ld_req = 1'b0;
  endtask

  task automatic pulse_start(input logic [3:0] p);
    @(negedge clk); start_i = 1'b1; phase_i = p;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); man_t = 1'b1;
    @(negedge clk); man_t = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_tout);
    got_done = 0; got_tout = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done_o || timeout_o) begin got_done = done_o; got_tout = timeout_o; break; end
      @(negedge clk);
    end
  endtask

  // phase, lag, initial register
  localparam logic [39:0] VEC [0:5] = '{
    {4'd0,  4'd0, 32'h0000_0000},
    {4'd5,  4'd3, 32'hA5A5_5A5A},
    {4'd10, 4'd7, 32'hFFFF_FFFF},
    {4'd15, 4'd1, 32'h0005_0000},
    {4'd7,  4'd5, 32'h1234_5678},
    {4'd12, 4'd2, 32'h8000_0001}
  };

  initial begin
    bit d, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !timeout_o && !cfg_wr_o, "R9 reset state",
        {28'd0, busy_o, done_o, timeout_o, cfg_wr_o}, 32'd0);

    // vector table walk
    for (int k = 0; k < 6; k++) begin
      logic [3:0] p; logic [31:0] init;
      p = VEC[k][39:36]; lag = int'(VEC[k][35:32]); init = VEC[k][31:0];
      load(init);
      pulse_start(p);
      wait_end(d, t);
      chk(d && !t, "R6 sequence completes", {30'd0, d, t}, 32'd2);
      chk(mreg == final_val(init, p), "R3 final register (Gray code at 23:20)", mreg, final_val(init, p));
      chk(wr_cnt == 4, "R6 four writes", wr_cnt, 4);
      @(negedge clk);
      chk(!done_o && !busy_o, "R9 done single cycle", {31'd0, done_o}, 0);
    end

    // start while busy is ignored
    lag = 6; load(32'h0000_0000);
    pulse_start(4'd3);
    @(negedge clk); start_i = 1'b1; phase_i = 4'd12;
    @(negedge clk); start_i = 1'b0;
    wait_end(d, t);
    repeat (20) @(negedge clk);
    chk(mreg[23:20] == gray(4'd3), "R8 phase unaffected by busy start", mreg[23:20], gray(4'd3));
    chk(wr_cnt == 4 && done_cnt == 1, "R8 writes/done count", wr_cnt * 16 + done_cnt, 65);

    // stuck status: no ticks -> wait, 48 ticks -> still busy, 49th -> timeout
    auto_en = 1'b0; lag = 0; hold_en = 1'b1; hold_val = 1'b1;
    load(32'h0004_0000);
    pulse_start(4'd6);
    repeat (200) @(negedge clk);
    chk(busy_o && !timeout_o, "R10 no ticks no timeout", {30'd0, busy_o, timeout_o}, 32'd2);
    for (int i = 0; i < 48; i++) begin tick1(); @(negedge clk); end
    chk(busy_o && !timeout_o, "R7 48 ticks still polling", {30'd0, busy_o, timeout_o}, 32'd2);
    tick1();
    chk(timeout_o && !done_o, "R7 timeout on 50th attempt", {31'd0, timeout_o}, 1);
    @(negedge clk);
    chk(!timeout_o && !busy_o, "R9 timeout single cycle", {30'd0, busy_o, timeout_o}, 0);
    chk(wr_cnt == 1, "R7 no writes after timeout", wr_cnt, 1);

    // match coincides with last-attempt tick
    load(32'h0004_0000);
    pulse_start(4'd9);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 48; i++) begin tick1(); @(negedge clk); end
    @(negedge clk); man_t = 1'b1; hold_en = 1'b0;
    @(negedge clk); man_t = 1'b0;
    chk(!timeout_o, "R10 match wins over expiry", {31'd0, timeout_o}, 0);
    wait_end(d, t);
    chk(d && !t, "R10 sequence completes after collision", {30'd0, d, t}, 32'd2);
    chk(mreg == final_val(32'h0004_0000, 4'd9), "R5 final register after collision",
        mreg, final_val(32'h0004_0000, 4'd9));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule